// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host end of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low chip select and a shift clock derived from the system clock, and shifts in the converter's serial data. Each frame starts with the chip select falling while the shift clock is low. The converter sends two zero bits, then twelve data bits with the most significant bit first, then two optional trailing zeros. The controller drops the zero bits and returns the twelve data bits on a parallel output together with a one-cycle valid strobe.

Three operations share the one frame engine. A conversion runs a 14- or 16-clock frame and delivers a result. A sleep request stops the frame early, inside the window in which releasing chip select powers the converter down. A wake request runs a full 16-clock dummy frame and discards its result. The caller chooses the half-period of the shift clock, the frame length, the capture edge (rising or falling) and a minimum chip-select-high time. The frame length, capture edge and half-period are latched when a frame starts. A busy output covers the whole frame and the recovery gap after it, and requests that arrive while busy are ignored.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is active and immediately after it, `cs_n`=1, `sck`=0, `busy`=0 and `result_valid`=0.
- R2: `sck` is low whenever `cs_n` is high, and `cs_n` falls only while `sck` is low. The first `sck` edge after `cs_n` falls is a rising edge.
- R3: Every high phase and every low phase of `sck` inside a frame lasts exactly `cfg_half_div` system clocks. A value of 0 is treated as 1.
- R4: A conversion frame has 14 falling `sck` edges when `cfg_long_frame`=0 and 16 when it is 1. `cs_n` rises one half-period after the last falling edge.
- R5: `result` holds frame bits 2 through 13, counted from 0 at the bit that the falling `cs_n` launches. These are the twelve data bits, with the most significant bit in `result[11]`. The alignment is the same for rising capture (`cfg_rise_capture`=1), for falling capture (0) and for both frame lengths.
- R6: `result_valid` is high for exactly one cycle, the cycle in which `cs_n` has just risen at the end of a conversion frame. It is never high after a sleep frame or a wake frame.
- R7: A sleep request produces a frame in which `cs_n` rises after exactly 3 falling `sck` edges, which lies inside the 2nd-to-10th-edge power-down window.
- R8: A wake request produces a 16-falling-edge frame whose data is discarded.
- R9: Between two frames, `cs_n` stays high for at least as many cycles as the `cfg_cs_gap` value latched for the earlier frame, and `busy` stays high until that time has elapsed.
- R10: Requests that arrive while `busy` is high are ignored. When requests arrive together, wake takes priority over sleep, and sleep over conversion.
- R11: `busy` rises in the cycle after a request is accepted and falls when the controller can accept the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_div | input | DIV_W | Shift-clock half-period in system clocks (0 treated as 1) |
| cfg_long_frame | input | 1 | 1 = 16-clock frame, 0 = 14-clock frame |
| cfg_rise_capture | input | 1 | 1 = sample data on rising sck, 0 = on falling sck |
| cfg_cs_gap | input | GAP_W | Minimum chip-select-high cycles after a frame |
| conv_req | input | 1 | Start a conversion |
| sleep_req | input | 1 | Run an aborted frame that powers the converter down |
| wake_req | input | 1 | Run a dummy frame that powers the converter up |
| sdo_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Shift clock |
| busy | output | 1 | A frame or the recovery gap is in progress |
| result | output | DATA_W | Last conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that the converter changes its data output only after a falling shift-clock edge, and that the configuration inputs change only while `busy` is low. The bench models the converter as a serial source. The model advances its bit index on each observed falling edge of `sck`, half a system clock after that edge, so both capture edges see settled data. The bench changes the configuration and raises requests only between frames. It does raise extra requests while a frame runs, to check that they are ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } rd_state_e;

  typedef enum logic [1:0] {
    OP_CONV,
    OP_SLEEP,
    OP_WAKE
  } rd_op_e;

  // Number of falling shift-clock edges a frame of the given kind runs.
  function automatic int unsigned frame_edges(rd_op_e op, logic long16,
                                              int unsigned sleep_cut,
                                              int unsigned data_w);
    int unsigned n;
    case (op)
      OP_SLEEP: n = sleep_cut;
      OP_WAKE:  n = data_w + 4;
      default:  n = long16 ? data_w + 4 : data_w + 2;
    endcase
    return n;
  endfunction

  // Capture slot k (0-based) carries frame bit k; data sits in slots 2..data_w+1.
  function automatic logic in_data_slot(int unsigned slot, int unsigned data_w);
    return (slot >= 2) && (slot < data_w + 2);
  endfunction

  // Clamp the sleep cut point into the legal power-down window.
  function automatic int unsigned clamp_cut(int unsigned cut);
    if (cut < 3) return 3;
    if (cut > 10) return 10;
    return cut;
  endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick    = run && (cnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + DIV_W'(1);
  end

  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div_eff));
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              sdo,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(DATA_W + 5);

  logic [CNT_W-1:0] slot;
  logic             take;

  assign take = cap_en && in_data_slot(32'(slot), DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      data <= '0;
    end else if (clear) begin
      slot <= '0;
    end else if (cap_en) begin
      slot <= slot + CNT_W'(1);
      if (take) data <= {data[DATA_W-2:0], sdo};
    end
  end

  p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (32'(slot) < DATA_W + 4));
endmodule

// File: rtl/adc_rd_gap.sv
module adc_rd_gap #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] gap,
  output logic             done
);
  logic [GAP_W-1:0] cnt;

  assign done = run && (({1'b0, cnt} + {{GAP_W{1'b0}}, 1'b1}) >= {1'b0, gap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                   cnt <= cnt + GAP_W'(1);
  end

  p_gap_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (run && (cnt == $past(cnt) + GAP_W'(1))) || !run);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int DIV_W      = 8,
  parameter int GAP_W      = 8,
  parameter int SLEEP_EDGE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              cfg_long_frame,
  input  logic              cfg_rise_capture,
  input  logic [GAP_W-1:0]  cfg_cs_gap,
  input  logic              conv_req,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              sdo_in,
  output logic              cs_n,
  output logic              sck,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);
  localparam int EDGE_W    = $clog2(DATA_W + 5);
  localparam int SLEEP_CUT = clamp_cut(SLEEP_EDGE);

  rd_state_e         state;
  rd_op_e            op_q;
  logic              long_q;
  logic              rise_q;
  logic [DIV_W-1:0]  div_q;
  logic [GAP_W-1:0]  gap_q;
  logic [EDGE_W-1:0] fall_cnt;
  logic [DATA_W-1:0] cap_data;

  // Named internal events
  logic        any_req;
  logic        accept;
  rd_op_e      op_pick;
  logic        half_tick;
  logic        clk_run;
  logic        cap_en;
  logic        last_fall;
  logic        gap_done;
  int unsigned edge_target;

  assign any_req  = conv_req | sleep_req | wake_req;
  assign accept   = (state == ST_IDLE) && any_req;
  assign op_pick  = wake_req ? OP_WAKE : (sleep_req ? OP_SLEEP : OP_CONV);
  assign clk_run  = (state == ST_SETUP) || (state == ST_HIGH) ||
                    (state == ST_LOW)   || (state == ST_TAIL);
  assign edge_target = frame_edges(op_q, long_q, SLEEP_CUT, DATA_W);
  assign last_fall   = (state == ST_HIGH) && half_tick &&
                       (32'(fall_cnt) + 32'd1 == edge_target);
  assign cap_en = half_tick && (rise_q ? ((state == ST_SETUP) || (state == ST_LOW))
                                       : (state == ST_HIGH));
  assign busy   = (state != ST_IDLE);

  adc_rd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (clk_run),
    .half_div (div_q),
    .tick     (half_tick)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .cap_en (cap_en),
    .sdo    (sdo_in),
    .data   (cap_data)
  );

  adc_rd_gap #(.GAP_W(GAP_W)) gap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_GAP),
    .gap   (gap_q),
    .done  (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      op_q         <= OP_CONV;
      long_q       <= 1'b0;
      rise_q       <= 1'b0;
      div_q        <= '0;
      gap_q        <= '0;
      fall_cnt     <= '0;
      cs_n         <= 1'b1;
      sck          <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n     <= 1'b0;
            op_q     <= op_pick;
            long_q   <= cfg_long_frame;
            rise_q   <= cfg_rise_capture;
            div_q    <= cfg_half_div;
            gap_q    <= cfg_cs_gap;
            fall_cnt <= '0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (half_tick) begin
            sck   <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (half_tick) begin
            sck      <= 1'b0;
            fall_cnt <= fall_cnt + EDGE_W'(1);
            state    <= last_fall ? ST_TAIL : ST_LOW;
          end
        end
        ST_LOW: begin
          if (half_tick) begin
            sck   <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_TAIL: begin
          if (half_tick) begin
            cs_n <= 1'b1;
            if (op_q == OP_CONV) begin
              result       <= cap_data;
              result_valid <= 1'b1;
            end
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Observation counters for the assertions
  logic             sck_q;
  logic [DIV_W:0]   hold_cnt;
  logic [GAP_W:0]   hi_cnt;
  logic [DIV_W-1:0] div_eff_q;

  assign div_eff_q = (div_q == '0) ? DIV_W'(1) : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      hold_cnt <= '1;
      hi_cnt   <= '1;
    end else begin
      sck_q <= sck;
      if (sck != sck_q)    hold_cnt <= (DIV_W+1)'(1);
      else if (~&hold_cnt) hold_cnt <= hold_cnt + (DIV_W+1)'(1);
      if (!cs_n)           hi_cnt <= '0;
      else if (~&hi_cnt)   hi_cnt <= hi_cnt + (GAP_W+1)'(1);
    end
  end

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_cs_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck && !$past(sck));
  p_half_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sck != $past(sck)) && !$past(cs_n)) |-> (hold_cnt >= {1'b0, div_eff_q}));
  p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fall_cnt) <= DATA_W + 4);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_valid_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !$past(cs_n) && op_q == OP_CONV));
  p_sleep_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && op_q == OP_SLEEP) |-> (32'(fall_cnt) == SLEEP_CUT));
  p_gap_met_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= {1'b0, $past(gap_q)}));
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(state) == ST_IDLE));
  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> busy);
endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb_top;
  localparam int DATA_W = 12;
  localparam int DIV_W  = 8;
  localparam int GAP_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_half_div = '0;
  logic cfg_long_frame = 1'b0;
  logic cfg_rise_capture = 1'b0;
  logic [GAP_W-1:0] cfg_cs_gap = '0;
  logic conv_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic sdo = 1'b0;
  logic cs_n, sck, busy, result_valid;
  logic [DATA_W-1:0] result;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div),
    .cfg_long_frame(cfg_long_frame), .cfg_rise_capture(cfg_rise_capture),
    .cfg_cs_gap(cfg_cs_gap), .conv_req(conv_req), .sleep_req(sleep_req),
    .wake_req(wake_req), .sdo_in(sdo), .cs_n(cs_n), .sck(sck), .busy(busy),
    .result(result), .result_valid(result_valid));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Converter model and link monitor
  logic [DATA_W-1:0] slave_data = '0;
  int bit_idx = 0, fall_cnt = 0, run = 0, hi_run = 1000;
  int frames = 0, last_falls = 0, valid_cnt = 0;
  int cs_sck_bad = 0, half_bad = 0, gap_bad = 0, vbad = 0;
  int div_eff = 1, gap_prev = 0;
  logic [DATA_W-1:0] last_result = '0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        if (sck) cs_sck_bad++;
        if (hi_run < gap_prev) gap_bad++;
        fall_cnt = 0; bit_idx = 0; run = 1; hi_run = 0;
      end else if (!cs_n) begin
        if (sck != prev_sck) begin
          if (run != div_eff) half_bad++;
          run = 1;
          if (prev_sck && !sck) begin fall_cnt++; bit_idx++; end
        end else run++;
      end
      if (cs_n) hi_run++;
      if (cs_n && sck) cs_sck_bad++;
      if (!prev_cs && cs_n) begin frames++; last_falls = fall_cnt; end
      if (result_valid) begin
        valid_cnt++; last_result = result;
        if (!(cs_n && !prev_cs)) vbad++;
      end
      sdo = (!cs_n && bit_idx >= 2 && bit_idx < 14) ? slave_data[13-bit_idx] : 1'b0;
      prev_cs = cs_n; prev_sck = sck;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_falls(int op, bit long16);
    if (op == 1) return 3;
    if (op == 2) return 16;
    return long16 ? 16 : 14;
  endfunction

  // op: 0 conversion, 1 sleep, 2 wake, 3 wake+conv together
  task automatic run_op(input int op, input int div, input bit long16, input bit rise,
                        input int gap, input logic [DATA_W-1:0] data, input bit extra);
    int f0, v0, eop, tmo;
    @(negedge clk);
    cfg_half_div = DIV_W'(div); cfg_long_frame = long16; cfg_rise_capture = rise;
    cfg_cs_gap = GAP_W'(gap); slave_data = data;
    f0 = frames; v0 = valid_cnt;
    conv_req = (op == 0 || op == 3); sleep_req = (op == 1); wake_req = (op >= 2);
    @(negedge clk);
    conv_req = 0; sleep_req = 0; wake_req = 0;
    div_eff = (div == 0) ? 1 : div;
    check(busy === 1'b1 && cs_n === 1'b0, "R11 busy after accept", busy, 1);
    if (extra) begin
      repeat (3) @(negedge clk);
      conv_req = 1; sleep_req = 1;
      @(negedge clk);
      conv_req = 0; sleep_req = 0;
    end
    tmo = 0;
    while (busy && tmo < 20000) begin @(negedge clk); tmo++; end
    check(tmo < 20000, "R11 busy released", tmo, 0);
    eop = (op == 3) ? 2 : op;
    check(frames - f0 == 1, "R10 one frame per request", frames - f0, 1);
    check(last_falls == exp_falls(eop, long16),
          eop == 1 ? "R7 sleep cut edges" : (eop == 2 ? "R8 wake frame edges" : "R4 frame edges"),
          last_falls, exp_falls(eop, long16));
    check(valid_cnt - v0 == ((eop == 0) ? 1 : 0), "R6 valid count", valid_cnt - v0,
          (eop == 0) ? 1 : 0);
    if (eop == 0)
      check(last_result == data, "R5 result alignment", int'(last_result), int'(data));
    check(half_bad == 0, "R3 half period", half_bad, 0);
    check(cs_sck_bad == 0, "R2 cs/sck order", cs_sck_bad, 0);
    check(gap_bad == 0, "R9 cs high gap", gap_bad, 0);
    check(vbad == 0, "R6 valid timing", vbad, 0);
    gap_prev = gap;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && result_valid === 1'b0,
          "R1 reset outputs", {cs_n, sck, busy, result_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n === 1'b1 && busy === 1'b0, "R1 after reset", {cs_n, busy}, 2'b10);
    // directed corners
    run_op(2, 2, 0, 1, 3, 12'h000, 0);
    run_op(0, 1, 0, 1, 0, 12'hFFF, 0);
    run_op(0, 1, 0, 0, 0, 12'h800, 0);
    run_op(0, 3, 1, 1, 5, 12'h001, 0);
    run_op(0, 3, 1, 0, 5, 12'hA5C, 0);
    run_op(0, 0, 0, 0, 9, 12'h3C6, 0);
    run_op(1, 2, 1, 1, 4, 12'h777, 0);
    run_op(3, 2, 0, 0, 2, 12'h123, 0);
    run_op(0, 2, 1, 1, 20, 12'h9E1, 1);
    run_op(0, 1, 0, 0, 1, 12'h456, 0);
    // constrained random
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 40; i++) begin
      int r, op;
      r = int'($urandom % 10);
      op = (r < 7) ? 0 : ((r < 8) ? 1 : ((r < 9) ? 2 : 3));
      run_op(op, int'($urandom % 5), 1'($urandom), 1'($urandom), int'($urandom % 12),
             DATA_W'($urandom), (i % 5) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule